// File: doc/BRIEF.md
# Column-Blocked Matrix-Vector Engine

This block computes a dense matrix-vector product y = M·x with signed fixed-point arithmetic. The square weight matrix is written once through a preload port into small per-lane RAM banks and stays there across any number of runs. A run begins with a start pulse. The engine then takes the input vector as a stream of DIM elements and returns the DIM output elements as a stream, in ascending row order. A one-cycle done pulse closes the run.

The columns are split into N_CB contiguous column blocks. Each multiply-accumulate lane owns one row within one column block. It keeps that row's partial dot product in its own accumulator register while the column indices of its block are issued one per cycle. The same column offset is issued in every block at once, and each block's lanes receive that block's input element by broadcast. Once the last column has been accumulated, a reduction stage per row adds the column-block partials and saturates the sum to 32 bits.

Lanes are grouped into clusters. The lane count sets how many rows one tile holds. A taller matrix is processed as a series of row tiles, and the accumulators restart at the first column of every tile.

Top module: `cbmv_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `done` and `in_ready` are 0.
- R2: After `start` is sampled high in idle, `in_ready` is 1 until exactly DIM input elements have been accepted, in index order 0..DIM-1. It then drops to 0 and stays low for the rest of the run.
- R3: Output element r equals the sum over all columns c of M[r][c]·x[c], with 16-bit signed operands. This value combines the partials of every column block.
- R4: Output elements leave in ascending row order 0..DIM-1, one per `out_valid && out_ready` cycle. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R5: Row tiles are independent. The accumulators restart at the start of every tile, so no tile's result contains products from an earlier tile.
- R6: A row sum above 2^31-1 is output as 2147483647, and a row sum below -2^31 is output as -2147483648.
- R7: `done` is high for exactly one cycle. That cycle immediately follows the cycle in which the last output element is accepted.
- R8: `start` has no effect while a run is in progress. The run accepts DIM elements and produces its DIM correct results unchanged.
- R9: The preload port writes the weight at row `wr_row` and column `wr_col`, where both are plain matrix indices. Weights persist across runs without being reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled in idle only) |
| in_valid | input | 1 | Input element valid |
| in_data | input | DW | Signed input vector element |
| in_ready | output | 1 | Engine accepts an input element |
| out_valid | output | 1 | Output element valid |
| out_data | output | OUTW | Saturated signed output element |
| out_ready | input | 1 | Consumer accepts the output element |
| done | output | 1 | One-cycle end-of-run pulse |
| wr_en | input | 1 | Weight write strobe |
| wr_row | input | $clog2(DIM) | Weight row index |
| wr_col | input | $clog2(DIM) | Weight column index |
| wr_data | input | DW | Signed weight value |

## Verification
Random signed matrices and vectors exercise the full dot product. Because every column carries a distinct weight, a lost or duplicated column block partial shows up in the result. A matrix whose lower row tile is all zeros exposes accumulators that fail to restart between tiles. A second run on the same weights with a fresh vector shows whether the weights persisted. Extreme all-positive and all-negative rows separate correct clamping from wrap-around. A run with periodic back-pressure and a stray start pulse during loading tests the ordering, the hold behaviour and the rejection of a mid-run start.

// File: rtl/cbmv_pkg.sv
package cbmv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CALC,
    ST_DRAIN,
    ST_RED,
    ST_EMIT
  } cbmv_state_e;
endpackage

// File: rtl/cbmv_lane.sv
module cbmv_lane #(
  parameter int DW    = 16,
  parameter int ACCW  = 40,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic signed [DW-1:0]   wr_data,
  input  logic [AW-1:0]          rd_addr,
  input  logic                   mac_v,
  input  logic                   mac_first,
  input  logic signed [DW-1:0]   x_in,
  output logic signed [ACCW-1:0] acc
);
  logic signed [DW-1:0] bank [DEPTH];
  logic signed [DW-1:0] rd_q;
  logic signed [2*DW-1:0] prod;

  // private row bank, synchronous read so it maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) bank[wr_addr] <= wr_data;
    rd_q <= bank[rd_addr];
  end

  assign prod = rd_q * x_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (mac_v) begin
      if (mac_first) acc <= ACCW'(prod);
      else           acc <= acc + ACCW'(prod);
    end
  end
endmodule

// File: rtl/cbmv_reduce.sv
module cbmv_reduce #(
  parameter int ACCW = 40,
  parameter int OUTW = 32,
  parameter int N_CB = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [N_CB*ACCW-1:0]   parts,
  output logic signed [OUTW-1:0] res
);
  localparam int SW = ACCW + $clog2(N_CB) + 1;
  localparam logic signed [SW-1:0] MAXV = SW'({1'b0, {(OUTW-1){1'b1}}});
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

  logic signed [SW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int b = 0; b < N_CB; b++) begin
      sum = sum + SW'($signed(parts[b*ACCW +: ACCW]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res <= '0;
    end else if (en) begin
      if (sum > MAXV)      res <= {1'b0, {(OUTW-1){1'b1}}};
      else if (sum < MINV) res <= {1'b1, {(OUTW-1){1'b0}}};
      else                 res <= OUTW'(sum);
    end
  end
endmodule

// File: rtl/cbmv_engine.sv
module cbmv_engine #(
  parameter int DIM               = 8,
  parameter int DW                = 16,
  parameter int ACCW              = 40,
  parameter int OUTW              = 32,
  parameter int N_CB              = 2,
  parameter int N_CLUSTERS        = 2,
  parameter int LANES_PER_CLUSTER = 4,
  localparam int IW = $clog2(DIM)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   in_data,
  output logic                   in_ready,
  output logic                   out_valid,
  output logic signed [OUTW-1:0] out_data,
  input  logic                   out_ready,
  output logic                   done,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_row,
  input  logic [IW-1:0]          wr_col,
  input  logic signed [DW-1:0]   wr_data
);
  import cbmv_pkg::*;

  localparam int LANES = N_CLUSTERS * LANES_PER_CLUSTER;
  localparam int ROWS  = LANES / N_CB;
  localparam int CBW   = DIM / N_CB;
  localparam int TILES = DIM / ROWS;
  localparam int DEPTH = TILES * CBW;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = (CBW > 1) ? $clog2(CBW) : 1;
  localparam int TW    = (TILES > 1) ? $clog2(TILES) : 1;
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;

  cbmv_state_e st;
  logic [IW-1:0] in_cnt;
  logic [CW-1:0] col;
  logic [TW-1:0] tile;
  logic [RW-1:0] ridx;
  logic          done_q;
  logic          mac_v, mac_first;

  logic signed [DW-1:0]   xbuf [DIM];
  logic signed [DW-1:0]   xq   [N_CB];
  logic signed [ACCW-1:0] part [LANES];
  logic signed [OUTW-1:0] res  [ROWS];
  logic [N_CB*ACCW-1:0]   row_parts [ROWS];

  // preload decode: matrix (row, col) -> lane bank and address
  logic [AW-1:0] wr_addr;
  int            wr_cb, wr_rr;
  logic [AW-1:0] rd_addr;

  assign wr_cb   = int'(wr_col) / CBW;
  assign wr_rr   = int'(wr_row) % ROWS;
  assign wr_addr = AW'((int'(wr_row) / ROWS) * CBW + int'(wr_col) % CBW);
  assign rd_addr = AW'(int'(tile) * CBW + int'(col));

  // control
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      in_cnt    <= '0;
      col       <= '0;
      tile      <= '0;
      ridx      <= '0;
      done_q    <= 1'b0;
      mac_v     <= 1'b0;
      mac_first <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      mac_v     <= (st == ST_CALC);
      mac_first <= (st == ST_CALC) && (col == '0);
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_LOAD;
          in_cnt <= '0;
        end
        ST_LOAD: if (in_valid) begin
          in_cnt <= in_cnt + 1'b1;
          if (in_cnt == IW'(DIM-1)) begin
            st   <= ST_CALC;
            col  <= '0;
            tile <= '0;
          end
        end
        ST_CALC: begin
          col <= col + 1'b1;
          if (col == CW'(CBW-1)) st <= ST_DRAIN;
        end
        ST_DRAIN: st <= ST_RED;
        ST_RED: begin
          st   <= ST_EMIT;
          ridx <= '0;
        end
        ST_EMIT: if (out_ready) begin
          if (ridx == RW'(ROWS-1)) begin
            if (tile == TW'(TILES-1)) begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              tile <= tile + 1'b1;
              col  <= '0;
              st   <= ST_CALC;
            end
          end else begin
            ridx <= ridx + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // vector buffer and per-block broadcast register (data path, no reset)
  always_ff @(posedge clk) begin
    if (st == ST_LOAD && in_valid) xbuf[in_cnt] <= in_data;
    for (int b = 0; b < N_CB; b++) begin
      xq[b] <= xbuf[b*CBW + int'(col)];
    end
  end

  // lanes, grouped into clusters
  for (genvar cl = 0; cl < N_CLUSTERS; cl++) begin : g_cluster
    for (genvar ln = 0; ln < LANES_PER_CLUSTER; ln++) begin : g_lane
      localparam int L    = cl * LANES_PER_CLUSTER + ln;
      localparam int L_CB = L / ROWS;
      localparam int L_RR = L % ROWS;
      cbmv_lane #(.DW(DW), .ACCW(ACCW), .DEPTH(DEPTH)) i_lane (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en && (wr_cb == L_CB) && (wr_rr == L_RR)),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .mac_v     (mac_v),
        .mac_first (mac_first),
        .x_in      (xq[L_CB]),
        .acc       (part[L])
      );
    end
  end

  // reduction across column blocks, one unit per tile row
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar b = 0; b < N_CB; b++) begin : g_cb
      assign row_parts[r][b*ACCW +: ACCW] = part[b*ROWS + r];
    end
    cbmv_reduce #(.ACCW(ACCW), .OUTW(OUTW), .N_CB(N_CB)) i_reduce (
      .clk   (clk),
      .rst   (rst),
      .en    (st == ST_RED),
      .parts (row_parts[r]),
      .res   (res[r])
    );
  end

  assign in_ready  = (st == ST_LOAD);
  assign out_valid = (st == ST_EMIT);
  assign out_data  = res[ridx];
  assign done      = done_q;
endmodule

// File: rtl/cbmv_checker.sv
module cbmv_checker #(
  parameter int OUTW = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic signed [OUTW-1:0] out_data,
  input logic                   out_ready,
  input logic                   done
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !done && !in_ready)); // R1

  AST_NO_LOAD_WHILE_EMIT: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid)); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(out_valid && out_ready)); // R7
endmodule

bind cbmv_engine cbmv_checker #(.OUTW(OUTW)) i_cbmv_checker (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready),
  .done      (done)
);

// File: tb/test_cbmv_engine.sv
`timescale 1ns/1ps
module test_cbmv_engine;
  localparam int DIM  = 8;
  localparam int DW   = 16;
  localparam int OUTW = 32;
  localparam int IW   = $clog2(DIM);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic in_ready;
  logic out_valid;
  logic signed [OUTW-1:0] out_data;
  logic out_ready = 1'b0;
  logic done;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_row = '0;
  logic [IW-1:0] wr_col = '0;
  logic signed [DW-1:0] wr_data = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int W [DIM][DIM];
  int X [DIM];

  always #2.5 clk = ~clk;

  cbmv_engine i_cbmv_engine (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .done(done), .wr_en(wr_en), .wr_row(wr_row),
    .wr_col(wr_col), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expect_row(input int r);
    longint s = 0;
    for (int c = 0; c < DIM; c++) s += longint'(W[r][c]) * longint'(X[c]);
    if (s > 64'sd2147483647) s = 64'sd2147483647;
    if (s < -64'sd2147483648) s = -64'sd2147483648;
    return s;
  endfunction

  task automatic preload();
    for (int r = 0; r < DIM; r++) begin
      for (int c = 0; c < DIM; c++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_row = IW'(r); wr_col = IW'(c); wr_data = DW'(W[r][c]);
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one complete run; stall adds back-pressure, stray_start pulses start mid-load
  task automatic run_case(input string req, input bit stall, input bit stray_start);
    int i = 0;
    int n = 0;
    int cyc = 0;
    int early_done = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    in_valid = 1'b1;
    while (i < DIM) begin
      bit got;
      in_data = DW'(X[i]);
      start = (stray_start && i == 3) ? 1'b1 : 1'b0;
      got = in_ready;
      @(negedge clk);
      if (got) i++;
    end
    in_valid = 1'b0; start = 1'b0;
    check("R2 in_ready low after DIM elements", in_ready, 0);
    while (n < DIM) begin
      out_ready = (stall && (cyc % 3 == 1)) ? 1'b0 : 1'b1;
      if (done) early_done++;
      if (out_valid && out_ready) begin
        check($sformatf("%s R3 R4 row %0d", req, n), out_data, expect_row(n));
        n++;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
    check("R7 done not before last accept", early_done, 0);
    check("R7 done after last accept", done, 1);
    check("R7 out_valid low after run", out_valid, 0);
    @(negedge clk);
    check("R7 done lasts one cycle", done, 0);
    check("R2 in_ready low after run", in_ready, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 out_valid in reset", out_valid, 0);
    check("R1 done in reset", done, 0);
    check("R1 in_ready in reset", in_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 in_ready after reset", in_ready, 0);
  endtask

  task automatic t_random();
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++) W[r][c] = $signed(16'($urandom));
    for (int c = 0; c < DIM; c++) X[c] = $signed(16'($urandom));
    preload();
    run_case("random", 1'b0, 1'b0);
  endtask

  task automatic t_persist();
    for (int c = 0; c < DIM; c++) X[c] = (c * 37) - 100;
    run_case("R9 persist", 1'b0, 1'b0);
  endtask

  task automatic t_tile_clear();
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++) W[r][c] = (r < DIM/2) ? 1000 + 10*r + c : 0;
    for (int c = 0; c < DIM; c++) X[c] = 300 + c;
    preload();
    run_case("R5 tile clear", 1'b0, 1'b0);
  endtask

  task automatic t_saturate();
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++) W[r][c] = (r % 2 == 0) ? 32767 : -32768;
    for (int c = 0; c < DIM; c++) X[c] = 32767;
    preload();
    run_case("R6 saturate", 1'b0, 1'b0);
  endtask

  task automatic t_stall_start();
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++) W[r][c] = (r + 1) * (c % 2 == 0 ? 3 : -5) + c;
    for (int c = 0; c < DIM; c++) X[c] = 11 * c - 40;
    preload();
    run_case("R4 R8 stall and stray start", 1'b1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_random();
    t_persist();
    t_tile_clear();
    t_saturate();
    t_stall_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule